// File: doc/BRIEF.md
# Bus Cycle Strobe Sequencer

This block paces the control strobes of a single-master processor bus whose address and data share one set of wires. A requester offers a cycle (read, write or interrupt acknowledge, aimed at memory or I/O space). The sequencer then walks the clock states T1, T2, T3, as many wait states as the slave asks for through its ready input, and T4. A rising-edge state register gives the clock state. Falling-edge registers add the half-clock placement that the address latch pulse and the data enable window need.

A second master can ask for the bus with a hold request. The sequencer grants it only between cycles. While the grant lasts, the shareable control lines have their output enables dropped and read as logic one, and the two strobes that are never shared keep their idle levels. A request that arrives while the current cycle is finishing is queued, so that its T1 follows the current T4 with no idle clock in between.

Top module: `bus_strobe_seq`

## Requirements
- R1: A cycle always runs T1, T2, T3, zero or more Tw, then T4. The `tstate` output encodes 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4, 6 hold granted.
- R2: Ready is sampled at the rising edge that ends T3 or a Tw. When it is low another Tw follows, and when it is high T4 follows.
- R3: `ale` is high only during the second, low half of T1.
- R4: Kind 1 is write, kind 2 is interrupt acknowledge, and kinds 0 and 3 are reads. `wr_n` is low through T2, T3 and every Tw of a write, and `inta_n` is low through the same states of an acknowledge. Neither strobe is low in any other state.
- R5: For reads and acknowledges, `den_n` is low from the middle of T2 to the middle of T4. For writes it is low from the start of T2 to the middle of T4.
- R6: `mio` is high for a memory cycle (`req_mem`=1) and low for I/O or acknowledge. `dtr` is high only for writes. Both take their value at the edge where the cycle is accepted and hold until the next acceptance.
- R7: While `hold_ack` is high, `wr_oe`, `den_oe`, `mio_oe` and `dtr_oe` are low, and `wr_n`, `den_n`, `mio` and `dtr` read 1. `ale` stays low, `inta_n` stays high, and none of them change.
- R8: Hold is granted only from idle or at the end of a T4 with no queued cycle. Hold wins over a new request, and no request is taken while `hold_req` is high.
- R9: A request present while ready ends T3 or a Tw is taken (`req_taken` high). The status lines switch at the start of that T4, and T1 of the queued cycle follows T4 directly.
- R10: While reset is low, the block is idle with `ale` low, all strobes high, every output enable high and `hold_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A cycle is offered |
| req_kind | input | 2 | Cycle kind: 0/3 read, 1 write, 2 acknowledge |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| ready | input | 1 | Slave ready, sampled at the end of T3/Tw |
| hold_req | input | 1 | Another master asks for the bus |
| req_taken | output | 1 | Offered cycle is accepted at the coming rising edge |
| hold_ack | output | 1 | Bus handed over |
| tstate | output | 3 | Current clock state code |
| ale | output | 1 | Address latch pulse |
| wr_n | output | 1 | Write strobe, active low |
| wr_oe | output | 1 | Drive enable of wr_n |
| inta_n | output | 1 | Acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| den_oe | output | 1 | Drive enable of den_n |
| mio | output | 1 | Memory/IO select |
| mio_oe | output | 1 | Drive enable of mio |
| dtr | output | 1 | Transceiver direction, high to transmit |
| dtr_oe | output | 1 | Drive enable of dtr |

## Verification
The hardest case to reach is a new request colliding with the final ready edge of a write, because the status lines switch and the next T1 begins while the old write's data enable is still inside its T4. The bench reaches it by holding ready high and offering a read in the low half of T3. It then samples both halves of the following T4. A second directed run raises hold in the middle of a cycle and offers a request in T3 alongside it, which shows that the grant waits for T4 and takes priority over the queued request.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int TS_W   = 3;
  localparam int KIND_W = 2;

  typedef enum logic [TS_W-1:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5,
    TS_HOLD = 3'd6
  } tstate_e;

  localparam logic [KIND_W-1:0] K_READ  = 2'd0;
  localparam logic [KIND_W-1:0] K_WRITE = 2'd1;
  localparam logic [KIND_W-1:0] K_INTA  = 2'd2;

  // states in which command strobes are driven
  function automatic logic f_strobe_win(tstate_e s);
    return (s == TS_T2) || (s == TS_T3) || (s == TS_TW);
  endfunction

  function automatic logic f_is_write(logic [KIND_W-1:0] k);
    return k == K_WRITE;
  endfunction

  function automatic logic f_is_inta(logic [KIND_W-1:0] k);
    return k == K_INTA;
  endfunction

  // memory select: acknowledge cycles always address I/O space
  function automatic logic f_mio(logic [KIND_W-1:0] k, logic mem);
    return f_is_inta(k) ? 1'b0 : mem;
  endfunction

  function automatic logic f_dtr(logic [KIND_W-1:0] k);
    return f_is_write(k);
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_mem,
  input  logic              ready,
  input  logic              hold_req,
  output tstate_e           state_o,
  output logic              accept_o,
  output logic [KIND_W-1:0] cur_kind_o,
  output logic              cur_mem_o
);
  tstate_e           st_q, st_d;
  logic              pend_q, pend_d;
  logic [KIND_W-1:0] kind_q;
  logic              mem_q;

  // named events for the checks below
  logic in_data_phase;
  logic end_wait;
  logic take_idle;
  logic take_queued;

  assign in_data_phase = (st_q == TS_T3) || (st_q == TS_TW);
  assign end_wait      = in_data_phase && ready;
  assign take_idle     = req_valid && !hold_req && (st_q == TS_IDLE);
  assign take_queued   = req_valid && !hold_req && end_wait;
  assign accept_o      = take_idle || take_queued;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    case (st_q)
      TS_IDLE: begin
        if (hold_req)       st_d = TS_HOLD;
        else if (req_valid) st_d = TS_T1;
      end
      TS_T1: st_d = TS_T2;
      TS_T2: st_d = TS_T3;
      TS_T3, TS_TW: begin
        if (ready) begin
          st_d = TS_T4;
          if (take_queued) pend_d = 1'b1;
        end else begin
          st_d = TS_TW;
        end
      end
      TS_T4: begin
        pend_d = 1'b0;
        if (pend_q)        st_d = TS_T1;
        else if (hold_req) st_d = TS_HOLD;
        else               st_d = TS_IDLE;
      end
      TS_HOLD: if (!hold_req) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      pend_q <= 1'b0;
      kind_q <= K_READ;
      mem_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (accept_o) begin
        kind_q <= req_kind;
        mem_q  <= req_mem;
      end
    end
  end

  assign state_o    = st_q;
  assign cur_kind_o = kind_q;
  assign cur_mem_o  = mem_q;

  assert_t1_then_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_T1) |=> (st_q == TS_T2));
  assert_t2_then_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_T2) |=> (st_q == TS_T3));
  assert_wait_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_phase && !ready) |=> (st_q == TS_TW));
  assert_end_on_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    end_wait |=> (st_q == TS_T4));
  assert_hold_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_HOLD) |-> ($past(st_q) == TS_IDLE || $past(st_q) == TS_T4 ||
                           $past(st_q) == TS_HOLD));
  assert_queued_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_queued |=> ##1 (st_q == TS_T1));
endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic [KIND_W-1:0] cur_kind,
  output logic              ale_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              den_n_o
);
  logic ale_f_q;  // set at the falling edge inside T1
  logic den_f_q;  // set at falling edges inside T2/T3/Tw
  logic win;
  logic wr_act, inta_act, den_act;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_f_q <= 1'b0;
      den_f_q <= 1'b0;
    end else begin
      ale_f_q <= (state == TS_T1);
      den_f_q <= f_strobe_win(state);
    end
  end

  assign win      = f_strobe_win(state);
  assign wr_act   = win && f_is_write(cur_kind);
  assign inta_act = win && f_is_inta(cur_kind);
  // writes open the enable at the T2 rising edge, all kinds close it mid-T4
  assign den_act  = den_f_q || wr_act;

  assign ale_o    = ale_f_q && (state == TS_T1);
  assign wr_n_o   = !wr_act;
  assign inta_n_o = !inta_act;
  assign den_n_o  = !den_act;

  assert_ale_late_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T1) |-> ale_f_q);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!wr_n_o, !inta_n_o}));
  assert_den_covers_t2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T2) |-> !den_n_o);
  assert_den_off_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T1 || state == TS_IDLE || state == TS_HOLD) |-> den_n_o);
endmodule

// File: rtl/bus_seq_status.sv
module bus_seq_status
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic [KIND_W-1:0] cur_kind,
  input  logic              cur_mem,
  output logic              mio_o,
  output logic              dtr_o,
  output logic              float_o
);
  assign float_o = (state == TS_HOLD);
  // released lines are pulled up: they read as one while floating
  assign mio_o   = float_o ? 1'b1 : f_mio(cur_kind, cur_mem);
  assign dtr_o   = float_o ? 1'b1 : f_dtr(cur_kind);

  assert_status_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T1 || state == TS_T2) |=> ($stable(mio_o) && $stable(dtr_o)));
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_mem,
  input  logic              ready,
  input  logic              hold_req,
  output logic              req_taken,
  output logic              hold_ack,
  output logic [TS_W-1:0]   tstate,
  output logic              ale,
  output logic              wr_n,
  output logic              wr_oe,
  output logic              inta_n,
  output logic              den_n,
  output logic              den_oe,
  output logic              mio,
  output logic              mio_oe,
  output logic              dtr,
  output logic              dtr_oe
);
  tstate_e           state;
  logic [KIND_W-1:0] cur_kind;
  logic              cur_mem;
  logic              floating;

  bus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mem(req_mem), .ready(ready), .hold_req(hold_req),
    .state_o(state), .accept_o(req_taken),
    .cur_kind_o(cur_kind), .cur_mem_o(cur_mem)
  );

  bus_seq_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .state(state), .cur_kind(cur_kind),
    .ale_o(ale), .wr_n_o(wr_n), .inta_n_o(inta_n), .den_n_o(den_n)
  );

  bus_seq_status u_status (
    .clk(clk), .rst_n(rst_n), .state(state), .cur_kind(cur_kind),
    .cur_mem(cur_mem), .mio_o(mio), .dtr_o(dtr), .float_o(floating)
  );

  assign tstate   = state;
  assign hold_ack = floating;
  assign wr_oe    = !floating;
  assign den_oe   = !floating;
  assign mio_oe   = !floating;
  assign dtr_oe   = !floating;

  assert_float_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (wr_n && den_n && mio && dtr && !ale && inta_n));
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && $past(hold_ack)) |-> ($stable(ale) && $stable(inta_n) &&
                                       $stable(wr_n) && $stable(den_n)));
  assert_no_take_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !req_taken);
endmodule

// File: tb/bus_strobe_seq_tb_top.sv
module bus_strobe_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_mem = 1'b0;
  logic ready = 1'b1;
  logic hold_req = 1'b0;
  logic req_taken, hold_ack, ale, wr_n, wr_oe, inta_n, den_n, den_oe;
  logic mio, mio_oe, dtr, dtr_oe;
  logic [2:0] tstate;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mem(req_mem), .ready(ready), .hold_req(hold_req),
    .req_taken(req_taken), .hold_ack(hold_ack), .tstate(tstate), .ale(ale),
    .wr_n(wr_n), .wr_oe(wr_oe), .inta_n(inta_n), .den_n(den_n),
    .den_oe(den_oe), .mio(mio), .mio_oe(mio_oe), .dtr(dtr), .dtr_oe(dtr_oe)
  );

  // vector: kind[6:5] mem[4] waits[3:0]
  localparam logic [6:0] VEC [0:7] = '{
    {2'd0, 1'b1, 4'd0}, {2'd1, 1'b1, 4'd0}, {2'd2, 1'b1, 4'd0},
    {2'd0, 1'b0, 4'd2}, {2'd1, 1'b0, 4'd1}, {2'd2, 1'b0, 4'd3},
    {2'd3, 1'b1, 4'd1}, {2'd1, 1'b1, 4'd5}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // observed vector {tstate, ale, wr_n, inta_n, den_n, mio, dtr}
  function automatic logic [15:0] obs();
    return {7'd0, tstate, ale, wr_n, inta_n, den_n, mio, dtr};
  endfunction

  // expected vector restated from the requirements
  function automatic logic [15:0] model(input logic [2:0] ph, input bit low,
                                        input logic [1:0] k, input logic m);
    bit wr   = (k == 2'd1);
    bit ack  = (k == 2'd2);
    bit mid  = (ph == 3'd2) || (ph == 3'd3) || (ph == 3'd4);
    bit den;
    if (wr) den = mid || (ph == 3'd5 && !low);
    else    den = (ph == 3'd2 && low) || ph == 3'd3 || ph == 3'd4 || (ph == 3'd5 && !low);
    return {7'd0, ph, (ph == 3'd1) && low, !(mid && wr), !(mid && ack), !den,
            ack ? 1'b0 : m, wr};
  endfunction

  // starts in the low half of an idle clock; ends in the low half of idle
  task automatic run_cycle(input logic [1:0] k, input logic m, input int nw);
    int steps = 4 + nw;
    int tw = 0;
    req_valid = 1'b1; req_kind = k; req_mem = m; ready = 1'b1;
    #0;
    chk("R8 taken from idle", {15'd0, req_taken}, 16'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int s = 0; s < steps; s++) begin
      logic [2:0] ph;
      if (s == 0) ph = 3'd1;
      else if (s == 1) ph = 3'd2;
      else if (s == 2) ph = 3'd3;
      else if (s < 3 + nw) ph = 3'd4;
      else ph = 3'd5;
      if (ph == 3'd4) tw++;
      chk("R1,R3,R4,R5,R6 high half", obs(), model(ph, 1'b0, k, m));
      @(negedge clk); #1;
      chk("R1,R3,R4,R5,R6 low half", obs(), model(ph, 1'b1, k, m));
      if (ph == 3'd3 || ph == 3'd4) ready = (tw == nw);  // R2
      @(posedge clk); #1;
    end
    chk("R6 idle keeps status", obs(), {7'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1,
                                        (k == 2'd2) ? 1'b0 : m, k == 2'd1});
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset state", {3'd0, tstate, ale, wr_n, inta_n, den_n, hold_ack,
                            wr_oe, den_oe, mio_oe, dtr_oe, 2'd0},
        {3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0});
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;

    // table walk
    foreach (VEC[i]) run_cycle(VEC[i][6:5], VEC[i][4], int'(VEC[i][3:0]));

    // R9: back-to-back write then read
    req_valid = 1'b1; req_kind = 2'd1; req_mem = 1'b1; ready = 1'b1;
    @(posedge clk); #1; req_valid = 1'b0;               // T1
    @(posedge clk); #1;                                  // T2
    @(posedge clk); #1;                                  // T3
    @(negedge clk); #1;
    req_valid = 1'b1; req_kind = 2'd0; req_mem = 1'b0;
    #0;
    chk("R9 taken at end of T3", {15'd0, req_taken}, 16'd1);
    @(posedge clk); #1;                                  // T4
    chk("R9 T4 with new status", obs(), {7'd0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    req_valid = 1'b0;
    @(negedge clk); #1;
    chk("R5 write enable closes mid T4", {15'd0, den_n}, 16'd1);
    @(posedge clk); #1;
    chk("R9 T1 follows T4", {13'd0, tstate}, 16'd1);
    @(negedge clk); #1;
    chk("R3 ale in queued T1", {15'd0, ale}, 16'd1);
    @(posedge clk); #1;                                  // T2
    @(negedge clk); #1;
    chk("R5 read enable mid T2", {14'd0, den_n, wr_n}, 16'b01);
    @(posedge clk); #1;                                  // T3
    @(posedge clk); #1;                                  // T4
    @(posedge clk); #1;
    chk("R1 back to idle", {13'd0, tstate}, 16'd0);
    @(negedge clk); #1;

    // R7: hold while idle, request ignored
    hold_req = 1'b1;
    @(posedge clk); #1;
    chk("R7 grant outputs", {4'd0, tstate, hold_ack, wr_oe, den_oe, mio_oe, dtr_oe,
                             wr_n, den_n, mio, dtr},
        {4'd0, 3'd6, 1'b1, 4'b0000, 4'b1111});
    @(negedge clk); #1;
    req_valid = 1'b1; req_kind = 2'd2; req_mem = 1'b1;
    #0;
    chk("R8 no take during hold", {15'd0, req_taken}, 16'd0);
    @(posedge clk); #1;
    @(negedge clk); #1;
    chk("R7 ale/inta quiet", {9'd0, tstate, ale, inta_n, hold_ack, den_n},
        {9'd0, 3'd6, 1'b0, 1'b1, 1'b1, 1'b1});
    hold_req = 1'b0;
    @(posedge clk); #1;
    chk("R8 release to idle", {13'd0, tstate}, 16'd0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R8 held request starts", {13'd0, tstate}, 16'd1);
    @(posedge clk); #1; @(posedge clk); #1;              // T2, T3
    chk("R4 ack strobe in T3", {14'd0, inta_n, mio}, 16'b00);
    @(posedge clk); #1; @(posedge clk); #1;              // T4, idle
    @(negedge clk); #1;

    // R8: hold raised mid cycle waits for T4 and beats a request
    req_valid = 1'b1; req_kind = 2'd0; req_mem = 1'b1;
    @(posedge clk); #1; req_valid = 1'b0;                // T1
    @(posedge clk); #1;                                  // T2
    @(negedge clk); #1; hold_req = 1'b1;
    @(posedge clk); #1;                                  // T3
    chk("R8 no grant in T3", {12'd0, tstate, hold_ack}, {12'd0, 3'd3, 1'b0});
    @(negedge clk); #1;
    req_valid = 1'b1; req_kind = 2'd1;
    #0;
    chk("R8 hold blocks queued take", {15'd0, req_taken}, 16'd0);
    @(posedge clk); #1;
    chk("R8 T4 still owned", {12'd0, tstate, hold_ack}, {12'd0, 3'd5, 1'b0});
    @(posedge clk); #1;
    chk("R8 grant after T4", {12'd0, tstate, hold_ack}, {12'd0, 3'd6, 1'b1});
    @(negedge clk); #1; hold_req = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1; req_valid = 1'b0;
    chk("R8 request after release", {13'd0, tstate}, 16'd1);
    @(posedge clk); #1;                                  // T2 of write
    chk("R4 write strobe T2", {14'd0, wr_n, dtr}, 16'b01);
    #1 rst_n = 1'b0;                                     // R10 reset mid cycle
    #1;
    chk("R10 reset mid cycle", {10'd0, tstate, ale, wr_n, den_n},
        {10'd0, 3'd0, 1'b0, 1'b1, 1'b1});
    @(negedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 idle after reset", {13'd0, tstate}, 16'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule